// File: doc/BRIEF.md
# Command Mailbox Register Block

This block sits inside a memory-expander device and gives the host a command mailbox over a simple word-wide register bus. The host fills a payload buffer and writes an opcode and a payload length, then rings a doorbell. An internal command executor sees the doorbell through a device-side port. It reads and writes the same payload buffer and finishes by posting a return code and an output length. Posting the result clears the doorbell. From then until the next ring, everything the host can read back about that command is frozen.

A command that keeps running after it has been accepted reports progress through a background-status register. That register holds the opcode of the running command, a percent-complete value and a final return code. When the host has enabled it, a single-cycle interrupt pulse marks the moment the percentage reaches 100. A device-status register mirrors the mailbox-ready, fatal and firmware-halt indicators that the device drives.

The host address holds a word index. When its top bit is 1, the address selects the payload window and the low bits are the payload word index. When its top bit is 0, word indices 0 to 7 select the registers and every other index reads as zero.

Top module: `mbx_regs`

## Requirements
- R1: After reset the doorbell, the interrupt enable, the return code, the opcode, the length and the background percentage are all 0, `dev_ring` and `bg_irq` are 0, and the control word (index 1) reads 0.
- R2: The capability word (index 0) reads as follows. Bits [4:0] hold log2 of the payload size in bytes (PL_AW+2, at least 8). Bit 6 is set when the background interrupt is supported. Bits [11:8] hold the interrupt message number.
- R3: A host write to the control word (index 1) with bit 0 set raises the doorbell, and `dev_ring` goes high after that edge. A write with bit 0 clear never lowers the doorbell. Bit 1 of the same word is the interrupt enable and is stored on every control write.
- R4: While the doorbell is high, host writes to the opcode word (index 2, bits [15:0]), the length word (index 3, bits [20:0]) and the payload window are ignored, and a further doorbell write has no effect.
- R5: A `dev_done` pulse while the doorbell is high does three things at that edge. It loads `dev_rc` into the status word (index 4, bits [15:0]), loads `dev_out_len` into the length word and clears the doorbell.
- R6: While the doorbell is low, `dev_done` and device payload writes are ignored, so the status word, the length word and the payload stay unchanged until the next ring.
- R7: Host payload words written at a payload index read back at the same index. They are visible on the device read port one cycle after `dev_pl_addr` is presented. Device writes made while the doorbell is high are visible to the host.
- R8: `dev_len` presents the stored length clamped to the payload size in bytes (4 << PL_AW).
- R9: A `dev_done` with return code 0x0001 (started in background) does three things. It loads the current opcode into bits [15:0] of background word A (index 5), clears its percentage (bits [22:16]) and clears the background return code (index 6, bits [15:0]). A `dev_bg_we` pulse then stores `dev_bg_pct` and `dev_bg_rc`.
- R10: When the interrupt is supported and enabled, `bg_irq` is high for exactly one cycle after a `dev_bg_we` edge that moves the percentage from a value other than 100 to 100. Writing 100 again gives no pulse, and with the enable clear there is no pulse.
- R11: The device-status word (index 7) reads `stat_fatal` in bit 0, `stat_fwhalt` in bit 1 and `stat_ready` in bit 2.
- R12: Read data appears on `hrdata`, together with `hrd_valid`, one cycle after `hrd_en`. Register indices 8 and above in the register half read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hwr_en | input | 1 | Host write strobe |
| hrd_en | input | 1 | Host read strobe |
| haddr | input | PL_AW+1 | Host word address |
| hwdata | input | 32 | Host write data |
| hrdata | output | 32 | Host read data |
| hrd_valid | output | 1 | Read data valid |
| dev_ring | output | 1 | Doorbell level seen by the executor |
| dev_opcode | output | 16 | Command opcode |
| dev_len | output | 21 | Clamped input payload length |
| dev_done | input | 1 | Executor posts its result |
| dev_rc | input | 16 | Return code to post |
| dev_out_len | input | 21 | Output payload length to post |
| dev_pl_we | input | 1 | Device payload write |
| dev_pl_addr | input | PL_AW | Device payload word index |
| dev_pl_wdata | input | 32 | Device payload write data |
| dev_pl_rdata | output | 32 | Device payload read data |
| dev_bg_we | input | 1 | Background progress update |
| dev_bg_pct | input | 7 | Percent complete |
| dev_bg_rc | input | 16 | Background return code |
| stat_ready | input | 1 | Mailbox interface ready |
| stat_fatal | input | 1 | Device fatal indicator |
| stat_fwhalt | input | 1 | Firmware-halt indicator |
| bg_irq | output | 1 | Background-complete interrupt pulse |

## Verification
A doorbell stuck in the wrong state shows at the ports at once. Either `dev_ring` disagrees with the last ring or completion, or host writes land in (or bounce off) the opcode and payload during the next read. A frozen-state violation appears as a changed status, length or payload word on the first read after a stray device completion or device payload write. A wrong percentage history shows as a missing, doubled or unenabled `bg_irq` pulse in the cycle right after the progress update.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned OPC_W = 16;
  localparam int unsigned RC_W  = 16;
  localparam int unsigned LEN_W = 21;
  localparam int unsigned PCT_W = 7;

  localparam logic [RC_W-1:0]  RC_OK    = 16'h0000;
  localparam logic [RC_W-1:0]  RC_BG    = 16'h0001;
  localparam logic [PCT_W-1:0] PCT_DONE = 7'd100;

  typedef enum logic [2:0] {
    REG_CAP  = 3'd0,
    REG_CTRL = 3'd1,
    REG_OPC  = 3'd2,
    REG_LEN  = 3'd3,
    REG_STAT = 3'd4,
    REG_BGA  = 3'd5,
    REG_BGB  = 3'd6,
    REG_DEV  = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/mbx_pl_ram.sv
module mbx_pl_ram #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] ra_data,
  output logic [DW-1:0] rb_data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/mbx_bg_track.sv
module mbx_bg_track
  import mbx_pkg::*;
#(
  parameter bit IRQ_CAP = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OPC_W-1:0] load_opc,
  input  logic             upd_we,
  input  logic [PCT_W-1:0] upd_pct,
  input  logic [RC_W-1:0]  upd_rc,
  input  logic             irq_en,
  output logic [OPC_W-1:0] bg_opc,
  output logic [PCT_W-1:0] bg_pct,
  output logic [RC_W-1:0]  bg_rc,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bg_opc <= '0;
      bg_pct <= '0;
      bg_rc  <= '0;
    end else if (load) begin
      bg_opc <= load_opc;
      bg_pct <= '0;
      bg_rc  <= '0;
    end else if (upd_we) begin
      bg_pct <= upd_pct;
      bg_rc  <= upd_rc;
    end
  end

  generate
    if (IRQ_CAP) begin : g_irq
      logic irq_q;
      always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= irq_en && !load && upd_we &&
                          (upd_pct == PCT_DONE) && (bg_pct != PCT_DONE);
      end
      assign irq = irq_q;

      // R10: the pulse lasts one cycle
      p_irq_single_r10: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
      // R10: no pulse unless enabled at the update edge
      p_irq_enabled_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(irq_en));
      // R10: pulse only after a progress update
      p_irq_cause_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(upd_we));
    end else begin : g_noirq
      assign irq = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
  import mbx_pkg::*;
#(
  parameter int unsigned PL_AW   = 6,
  parameter bit          IRQ_CAP = 1'b1,
  parameter int unsigned MSG_NUM = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hwr_en,
  input  logic                hrd_en,
  input  logic [PL_AW:0]      haddr,
  input  logic [31:0]         hwdata,
  output logic [31:0]         hrdata,
  output logic                hrd_valid,
  output logic                dev_ring,
  output logic [15:0]         dev_opcode,
  output logic [20:0]         dev_len,
  input  logic                dev_done,
  input  logic [15:0]         dev_rc,
  input  logic [20:0]         dev_out_len,
  input  logic                dev_pl_we,
  input  logic [PL_AW-1:0]    dev_pl_addr,
  input  logic [31:0]         dev_pl_wdata,
  output logic [31:0]         dev_pl_rdata,
  input  logic                dev_bg_we,
  input  logic [6:0]          dev_bg_pct,
  input  logic [15:0]         dev_bg_rc,
  input  logic                stat_ready,
  input  logic                stat_fatal,
  input  logic                stat_fwhalt,
  output logic                bg_irq
);
  localparam int unsigned HA_W     = PL_AW + 1;
  localparam int unsigned SIZE_EXP = PL_AW + 2;
  localparam int unsigned PL_BYTES = 4 << PL_AW;
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(PL_BYTES);
  localparam logic [31:0] CAP_WORD = 32'(SIZE_EXP) |
                                     (32'(IRQ_CAP) << 6) |
                                     ((32'(MSG_NUM) & 32'hF) << 8);

  logic             db_q, irq_en_q;
  logic [OPC_W-1:0] opc_q;
  logic [LEN_W-1:0] len_q;
  logic [RC_W-1:0]  rc_q;
  logic [31:0]      reg_rd_q;
  logic             rd_pl_q;

  logic             is_pl, reg_hit;
  reg_idx_e         ridx;
  logic             host_pl_we, dev_we_ok, ram_we, post;
  logic [PL_AW-1:0] ram_waddr;
  logic [31:0]      ram_wdata, ram_a_data;
  logic [31:0]      reg_mux;
  logic [OPC_W-1:0] bg_opc;
  logic [PCT_W-1:0] bg_pct;
  logic [RC_W-1:0]  bg_rc;

  assign is_pl   = haddr[HA_W-1];
  assign reg_hit = !is_pl && (haddr[HA_W-2:3] == '0);
  assign ridx    = reg_idx_e'(haddr[2:0]);
  assign post    = dev_done && db_q;

  // doorbell, control and command fields
  always_ff @(posedge clk) begin
    if (rst) begin
      db_q     <= 1'b0;
      irq_en_q <= 1'b0;
      opc_q    <= '0;
      len_q    <= '0;
      rc_q     <= '0;
    end else begin
      if (hwr_en && reg_hit && ridx == REG_CTRL) irq_en_q <= hwdata[1];
      if (db_q) begin
        if (dev_done) begin
          db_q  <= 1'b0;
          rc_q  <= dev_rc;
          len_q <= dev_out_len;
        end
      end else if (hwr_en && reg_hit) begin
        case (ridx)
          REG_CTRL: if (hwdata[0]) db_q <= 1'b1;
          REG_OPC:  opc_q <= hwdata[OPC_W-1:0];
          REG_LEN:  len_q <= hwdata[LEN_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  // payload write port: host owns it while idle, device while ringing
  assign host_pl_we = hwr_en && is_pl && !db_q;
  assign dev_we_ok  = dev_pl_we && db_q;
  assign ram_we     = host_pl_we || dev_we_ok;
  assign ram_waddr  = db_q ? dev_pl_addr  : haddr[PL_AW-1:0];
  assign ram_wdata  = db_q ? dev_pl_wdata : hwdata;

  mbx_pl_ram #(.AW(PL_AW), .DW(32)) u_ram (
    .clk     (clk),
    .we      (ram_we),
    .waddr   (ram_waddr),
    .wdata   (ram_wdata),
    .ra_addr (haddr[PL_AW-1:0]),
    .rb_addr (dev_pl_addr),
    .ra_data (ram_a_data),
    .rb_data (dev_pl_rdata)
  );

  mbx_bg_track #(.IRQ_CAP(IRQ_CAP)) u_bg (
    .clk      (clk),
    .rst      (rst),
    .load     (post && dev_rc == RC_BG),
    .load_opc (opc_q),
    .upd_we   (dev_bg_we),
    .upd_pct  (dev_bg_pct),
    .upd_rc   (dev_bg_rc),
    .irq_en   (irq_en_q),
    .bg_opc   (bg_opc),
    .bg_pct   (bg_pct),
    .bg_rc    (bg_rc),
    .irq      (bg_irq)
  );

  always_comb begin
    reg_mux = '0;
    if (reg_hit) begin
      case (ridx)
        REG_CAP:  reg_mux = CAP_WORD;
        REG_CTRL: reg_mux = {30'b0, irq_en_q, db_q};
        REG_OPC:  reg_mux = {16'b0, opc_q};
        REG_LEN:  reg_mux = {11'b0, len_q};
        REG_STAT: reg_mux = {16'b0, rc_q};
        REG_BGA:  reg_mux = {9'b0, bg_pct, bg_opc};
        REG_BGB:  reg_mux = {16'b0, bg_rc};
        REG_DEV:  reg_mux = {29'b0, stat_ready, stat_fwhalt, stat_fatal};
        default:  reg_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hrd_valid <= 1'b0;
      rd_pl_q   <= 1'b0;
      reg_rd_q  <= '0;
    end else begin
      hrd_valid <= hrd_en;
      if (hrd_en) begin
        rd_pl_q  <= is_pl;
        reg_rd_q <= reg_mux;
      end
    end
  end

  assign hrdata     = rd_pl_q ? ram_a_data : reg_rd_q;
  assign dev_ring   = db_q;
  assign dev_opcode = opc_q;
  assign dev_len    = (len_q > LEN_MAX) ? LEN_MAX : len_q;

  // R3: doorbell rises only from a host write
  p_ring_by_host_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_ring) |-> $past(hwr_en));
  // R5: doorbell falls only on device completion
  p_clear_by_dev_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(dev_ring) |-> $past(dev_done));
  // R6: return code frozen while the doorbell is low
  p_status_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(dev_ring) |-> $stable(rc_q));
  // R4: opcode cannot change while ringing
  p_opcode_locked_r4: assert property (@(posedge clk) disable iff (rst)
    $past(dev_ring) |-> $stable(dev_opcode));
  // R12: one valid per read strobe
  p_read_valid_r12: assert property (@(posedge clk) disable iff (rst)
    hrd_en |=> hrd_valid);
endmodule

// File: tb/sim_mbx_regs.sv
`timescale 1ns/1ps
module sim_mbx_regs;
  localparam int unsigned PL_AW = 6;
  localparam logic [6:0] PL_BASE = 7'd64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hwr_en = 0, hrd_en = 0;
  logic [6:0]  haddr = '0;
  logic [31:0] hwdata = '0, hrdata;
  logic        hrd_valid, dev_ring, bg_irq;
  logic [15:0] dev_opcode;
  logic [20:0] dev_len;
  logic        dev_done = 0;
  logic [15:0] dev_rc = '0;
  logic [20:0] dev_out_len = '0;
  logic        dev_pl_we = 0;
  logic [5:0]  dev_pl_addr = '0;
  logic [31:0] dev_pl_wdata = '0, dev_pl_rdata;
  logic        dev_bg_we = 0;
  logic [6:0]  dev_bg_pct = '0;
  logic [15:0] dev_bg_rc = '0;
  logic        stat_ready = 0, stat_fatal = 0, stat_fwhalt = 0;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mbx_regs #(.PL_AW(PL_AW), .IRQ_CAP(1'b1), .MSG_NUM(3)) u0 (
    .clk, .rst, .hwr_en, .hrd_en, .haddr, .hwdata, .hrdata, .hrd_valid,
    .dev_ring, .dev_opcode, .dev_len, .dev_done, .dev_rc, .dev_out_len,
    .dev_pl_we, .dev_pl_addr, .dev_pl_wdata, .dev_pl_rdata,
    .dev_bg_we, .dev_bg_pct, .dev_bg_rc,
    .stat_ready, .stat_fatal, .stat_fwhalt, .bg_irq
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic host_wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    hwr_en = 1; haddr = a; hwdata = d;
    @(negedge clk);
    hwr_en = 0;
  endtask

  task automatic host_rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    hrd_en = 1; haddr = a;
    @(negedge clk);
    hrd_en = 0;
    d = hrdata;
    chk("R12 valid", {31'b0, hrd_valid}, 32'd1);
  endtask

  task automatic rd_chk(string tag, logic [6:0] a, logic [31:0] exp);
    logic [31:0] d;
    host_rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic dev_post(logic [15:0] rc, logic [20:0] olen);
    @(negedge clk);
    dev_done = 1; dev_rc = rc; dev_out_len = olen;
    @(negedge clk);
    dev_done = 0;
  endtask

  task automatic dev_wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    dev_pl_we = 1; dev_pl_addr = a; dev_pl_wdata = d;
    @(negedge clk);
    dev_pl_we = 0;
  endtask

  task automatic t_reset;
    chk("R1 ring", {31'b0, dev_ring}, 0);
    chk("R1 irq", {31'b0, bg_irq}, 0);
    rd_chk("R2 cap", 7'd0, 32'h0000_0348);
    rd_chk("R1 ctrl", 7'd1, 0);
    rd_chk("R1 stat", 7'd4, 0);
    rd_chk("R1 bga", 7'd5, 0);
    rd_chk("R12 unmapped", 7'd9, 0);
  endtask

  task automatic t_payload;
    host_wr(PL_BASE + 7'd0, 32'hA5A5_0001);
    host_wr(PL_BASE + 7'd63, 32'h1234_5678);
    rd_chk("R7 host pl0", PL_BASE + 7'd0, 32'hA5A5_0001);
    rd_chk("R7 host pl63", PL_BASE + 7'd63, 32'h1234_5678);
    @(negedge clk); dev_pl_addr = 6'd63;
    @(negedge clk);
    chk("R7 dev read", dev_pl_rdata, 32'h1234_5678);
  endtask

  task automatic t_ring;
    host_wr(7'd2, 32'h0000_4200);
    host_wr(7'd3, 32'd8);
    host_wr(7'd1, 32'd1);
    chk("R3 ring", {31'b0, dev_ring}, 1);
    chk("R3 opcode", {16'b0, dev_opcode}, 32'h4200);
    chk("R8 len small", {11'b0, dev_len}, 8);
    host_wr(7'd2, 32'h0000_1111);
    host_wr(7'd3, 32'd99);
    host_wr(PL_BASE + 7'd0, 32'hDEAD_BEEF);
    rd_chk("R4 opcode kept", 7'd2, 32'h4200);
    rd_chk("R4 len kept", 7'd3, 8);
    rd_chk("R4 payload kept", PL_BASE + 7'd0, 32'hA5A5_0001);
    host_wr(7'd1, 32'd0);
    chk("R3 no host clear", {31'b0, dev_ring}, 1);
    dev_wr(6'd1, 32'h0C0C_0C0C);
    dev_post(16'h0000, 21'd4);
    chk("R5 ring cleared", {31'b0, dev_ring}, 0);
    rd_chk("R5 status", 7'd4, 0);
    rd_chk("R5 out len", 7'd3, 4);
    rd_chk("R7 dev write seen", PL_BASE + 7'd1, 32'h0C0C_0C0C);
  endtask

  task automatic t_freeze;
    dev_wr(6'd1, 32'h0D0D_0D0D);
    dev_post(16'h0005, 21'd77);
    rd_chk("R6 status frozen", 7'd4, 0);
    rd_chk("R6 len frozen", 7'd3, 4);
    rd_chk("R6 payload frozen", PL_BASE + 7'd1, 32'h0C0C_0C0C);
  endtask

  task automatic t_clamp;
    host_wr(7'd3, 32'h001F_FFFF);
    chk("R8 len clamp", {11'b0, dev_len}, 256);
    host_wr(7'd3, 32'd256);
    chk("R8 len edge", {11'b0, dev_len}, 256);
  endtask

  task automatic t_bg;
    host_wr(7'd1, 32'd2);
    rd_chk("R3 irq enable", 7'd1, 2);
    host_wr(7'd2, 32'h0000_4400);
    host_wr(7'd1, 32'd3);
    dev_post(16'h0001, 21'd0);
    rd_chk("R9 bg load", 7'd5, 32'h0000_4400);
    rd_chk("R9 bg status rc", 7'd4, 1);
    @(negedge clk); dev_bg_we = 1; dev_bg_pct = 7'd50; dev_bg_rc = 16'h0;
    @(negedge clk); dev_bg_we = 0;
    chk("R10 no irq at 50", {31'b0, bg_irq}, 0);
    dev_bg_we = 1; dev_bg_pct = 7'd100; dev_bg_rc = 16'h0007;
    @(negedge clk); dev_bg_we = 0;
    chk("R10 irq pulse", {31'b0, bg_irq}, 1);
    @(negedge clk);
    chk("R10 irq one cycle", {31'b0, bg_irq}, 0);
    dev_bg_we = 1;
    @(negedge clk); dev_bg_we = 0;
    chk("R10 no repeat", {31'b0, bg_irq}, 0);
    rd_chk("R9 bg pct", 7'd5, (32'd100 << 16) | 32'h4400);
    rd_chk("R9 bg rc", 7'd6, 7);
  endtask

  task automatic t_noirq;
    host_wr(7'd1, 32'd0);
    host_wr(7'd1, 32'd1);
    dev_post(16'h0001, 21'd0);
    rd_chk("R9 pct reset", 7'd5, 32'h0000_4400);
    @(negedge clk); dev_bg_we = 1; dev_bg_pct = 7'd100;
    @(negedge clk); dev_bg_we = 0;
    chk("R10 disabled", {31'b0, bg_irq}, 0);
  endtask

  task automatic t_devstat;
    stat_ready = 1; stat_fatal = 0; stat_fwhalt = 1;
    rd_chk("R11 devstat a", 7'd7, 32'd6);
    stat_ready = 0; stat_fatal = 1; stat_fwhalt = 0;
    rd_chk("R11 devstat b", 7'd7, 32'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_payload;
    t_ring;
    t_freeze;
    t_clamp;
    t_bg;
    t_noirq;
    t_devstat;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule